// File: doc/BRIEF.md
# Modulo-4 Up/Down State Counter

This block is a small Moore machine that walks through four states in a ring, forward or backward each clock depending on a direction input, and presents the current position as a binary count. The state register is one-hot by default: each of the four states owns one flip-flop, and the binary count is formed by OR-ing the state bits that carry a given count bit. A build parameter swaps in a binary-encoded state register, so both implementations can be instantiated side by side and compared cycle for cycle.

The count depends only on the state register. It therefore changes only after a rising clock edge and never follows `dir_i` combinationally. An asynchronous active-low reset places the machine at count 0. If the one-hot register ever holds a code that is not one-hot, the machine returns to the count-0 state on the next edge.

Top module: `udc_counter`

## Requirements
- R1: While `rst_ni` is low, `count_o` is 0 regardless of `dir_i`. The reset acts at once, without waiting for a clock edge.
- R2: With `dir_i` = 1 at a rising edge, `count_o` advances by one, in the order 0, 1, 2, 3, then back to 0.
- R3: With `dir_i` = 0 at a rising edge, `count_o` steps back by one, in the order 0, 3, 2, 1, then back to 0.
- R4: `count_o` changes only on a rising edge of `clk_i`. Toggling `dir_i` between edges leaves `count_o` unchanged.
- R5: In one-hot mode, state bit k (k = 0..3) is the only set bit while the count is k. The next-state value is always exactly one-hot.
- R6: A one-hot state register that holds zero set bits, or more than one, loads the count-0 code 0001 on the next rising edge, whatever `dir_i` is.
- R7: The binary-encoded variant (`ENC` = `ENC_BINARY`) produces the same `count_o` sequence as the one-hot variant for the same reset and `dir_i` stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the state updates on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low; forces count 0 |
| dir_i | input | 1 | 1 counts up, 0 counts down |
| count_o | output | 2 | Binary count decoded from the state register |

## Verification
A direction applied before a rising edge shows up in `count_o` straight after that edge. The bench therefore drives `dir_i` on falling edges and compares `count_o` at the next falling edge, half a period after the update. Reset is the exception: it takes effect without a clock. Its checks sample 0.5 ns after `rst_ni` falls and again across the edges that pass while it is held. Illegal-code recovery is checked by forcing a bad code into the state register between edges and sampling the count after the single edge that must clear it.

// File: rtl/udc_pkg.sv
package udc_pkg;
  typedef enum logic {ENC_ONEHOT = 1'b0, ENC_BINARY = 1'b1} enc_e;

  // true when exactly one bit of a state vector is set
  function automatic logic onehot_ok(input logic [63:0] vec, input int unsigned width);
    int unsigned ones;
    ones = 0;
    for (int unsigned i = 0; i < 64; i++)
      if (i < width && vec[i]) ones++;
    return ones == 1;
  endfunction
endpackage

// File: rtl/udc_onehot_core.sv
module udc_onehot_core #(
  parameter int unsigned N_STATES = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                dir_i,
  output logic [N_STATES-1:0] state_o
);
  localparam logic [N_STATES-1:0] HOME_CODE = {{(N_STATES-1){1'b0}}, 1'b1};

  logic [N_STATES-1:0] state_q;
  logic [N_STATES-1:0] step;
  logic [N_STATES-1:0] state_d;
  logic                legal;

  // each bit: predecessor when going up, successor when going down
  for (genvar i = 0; i < N_STATES; i++) begin : g_step
    localparam int unsigned PRV = (i + N_STATES - 1) % N_STATES;
    localparam int unsigned NXT = (i + 1) % N_STATES;
    assign step[i] = (dir_i & state_q[PRV]) | (~dir_i & state_q[NXT]);
  end

  assign legal   = udc_pkg::onehot_ok(64'(state_q), N_STATES);
  assign state_d = legal ? step : HOME_CODE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= HOME_CODE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  AST_NEXT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(state_d)); // R5

  AST_ILLEGAL_RECOVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$onehot(state_q) |=> state_q == HOME_CODE); // R6
endmodule

// File: rtl/udc_onehot_decode.sv
module udc_onehot_decode #(
  parameter int unsigned N_STATES = 4,
  localparam int unsigned CNT_W   = $clog2(N_STATES)
) (
  input  logic [N_STATES-1:0] state_i,
  output logic [CNT_W-1:0]    count_o
);
  // OR of state indices whose bit is set
  always_comb begin
    count_o = '0;
    for (int unsigned i = 0; i < N_STATES; i++)
      if (state_i[i]) count_o = count_o | CNT_W'(i);
  end
endmodule

// File: rtl/udc_binary_core.sv
module udc_binary_core #(
  parameter int unsigned N_STATES = 4,
  localparam int unsigned CNT_W   = $clog2(N_STATES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dir_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  assign cnt_d = dir_i ? cnt_q + CNT_W'(1) : cnt_q - CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

  AST_UP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_i |=> count_o == CNT_W'($past(count_o) + CNT_W'(1))); // R2

  AST_DOWN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dir_i |=> count_o == CNT_W'($past(count_o) - CNT_W'(1))); // R3
endmodule

// File: rtl/udc_counter.sv
module udc_counter #(
  parameter udc_pkg::enc_e ENC      = udc_pkg::ENC_ONEHOT,
  parameter int unsigned   N_STATES = 4,
  localparam int unsigned  CNT_W    = $clog2(N_STATES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dir_i,
  output logic [CNT_W-1:0] count_o
);
  if (ENC == udc_pkg::ENC_ONEHOT) begin : g_onehot
    logic [N_STATES-1:0] state;
    udc_onehot_core #(.N_STATES(N_STATES)) u_core (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .dir_i  (dir_i),
      .state_o(state)
    );
    udc_onehot_decode #(.N_STATES(N_STATES)) u_dec (
      .state_i(state),
      .count_o(count_o)
    );
  end else begin : g_binary
    udc_binary_core #(.N_STATES(N_STATES)) u_core (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .dir_i  (dir_i),
      .count_o(count_o)
    );
  end

  always @(negedge clk_i)
    if (!rst_ni) AST_RESET_ZERO: assert (count_o == '0); // R1
endmodule

// File: tb/udc_counter_tb.sv
`timescale 1ns/1ps
module udc_counter_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b1;
  logic       dir_i = 1'b0;
  logic [1:0] cnt_oh;
  logic [1:0] cnt_bin;
  logic [1:0] ref_cnt;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  udc_counter #(.ENC(udc_pkg::ENC_ONEHOT)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .dir_i(dir_i), .count_o(cnt_oh));
  udc_counter #(.ENC(udc_pkg::ENC_BINARY)) dut_bin_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .dir_i(dir_i), .count_o(cnt_bin));

  // {dir, expected count after the edge}, starting from count 0
  localparam logic [2:0] VEC [16] = '{
    3'b101, 3'b110, 3'b111, 3'b100, 3'b101, 3'b000, 3'b011, 3'b010,
    3'b111, 3'b100, 3'b011, 3'b010, 3'b001, 3'b000, 3'b101, 3'b000};

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_both(input string req, input logic [1:0] exp);
    chk(req, cnt_oh, exp);
    chk({req, " (binary variant R7)"}, cnt_bin, exp);
  endtask

  task automatic step(input logic d);
    dir_i = d;
    @(negedge clk_i);
    ref_cnt = d ? ref_cnt + 2'd1 : ref_cnt - 2'd1;
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    #0.5 chk_both("R1 immediate reset", 2'd0);
    dir_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk_both("R1 reset held with dir=1", 2'd0);
    rst_ni = 1'b1;
    ref_cnt = 2'd0;

    // vector table: covers both wraps (R2, R3)
    foreach (VEC[i]) begin
      step(VEC[i][2]);
      chk_both(VEC[i][2] ? "R2 table up" : "R3 table down", VEC[i][1:0]);
      chk("R7 table vs model", cnt_bin, ref_cnt);
    end

    // R4: dir wiggles between edges do not move the count
    dir_i = 1'b1; #0.7 dir_i = 1'b0; #0.7 dir_i = 1'b1;
    chk_both("R4 no change between edges", ref_cnt);
    @(negedge clk_i);
    ref_cnt = ref_cnt + 2'd1;
    chk_both("R4 change after edge", ref_cnt);

    // random direction sequence against the modulo-4 model (R2, R3, R7)
    for (int k = 0; k < 300; k++) begin
      step(1'($urandom % 2));
      chk_both("R2/R3 random walk", ref_cnt);
    end

    // mid-run asynchronous reset (R1)
    #1 rst_ni = 1'b0;
    #0.5 chk_both("R1 mid-run reset", 2'd0);
    @(negedge clk_i);
    chk_both("R1 held across edge", 2'd0);
    rst_ni = 1'b1;
    ref_cnt = 2'd0;
    step(1'b1); step(1'b1);
    chk_both("R2 after reset release", 2'd2);

    // illegal code recovery (R6): two set bits, then none
    force dut_i.g_onehot.u_core.state_q = 4'b0110;
    #0.5 release dut_i.g_onehot.u_core.state_q;
    dir_i = 1'b1;
    @(negedge clk_i);
    chk("R6 two bits set recovers", cnt_oh, 2'd0);
    step(1'b0);
    chk("R5 legal after recovery", cnt_oh, 2'd3);
    force dut_i.g_onehot.u_core.state_q = 4'b0000;
    #0.5 release dut_i.g_onehot.u_core.state_q;
    dir_i = 1'b0;
    @(negedge clk_i);
    chk("R6 all zero recovers", cnt_oh, 2'd0);
    dir_i = 1'b0;
    @(negedge clk_i);
    chk("R5 one-hot resumes down count", cnt_oh, 2'd3);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #100000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule